// File: doc/BRIEF.md
# PCI Configuration Request Router

This block sits between a host and the configuration spaces of the devices on one bus segment and the bridges below it. Configuration accesses reach it by two paths. The first is a legacy pair of I/O ports: a 32-bit address latch, followed by a 4-byte data window whose byte and word accesses pick lanes of the addressed dword. The second is a memory-mapped window in which the bus, device, function and 12-bit register offset are carried directly in the address. Both paths reduce to one request that has a target bus, device/function, register offset, byte enables and aligned write data.

The router compares the target bus with the local bus number. A local target goes to the device register files through a select strobe and a presence flag. A remote bus is forwarded to the first enabled bridge whose inclusive secondary..subordinate range covers it. A read that finds no target completes at once with all-ones. A write that finds no target is dropped. A read that hits a device or bridge completes one cycle later, and the router stalls new requests during that cycle.

Top module: `cfg_req_router`

## Requirements
- R1: A 4-byte write to the latch port (default 0xCF8) stores all 32 bits, and a 4-byte read of that port returns the stored value with a response in the same cycle. The latch resets to zero.
- R2: A 1- or 2-byte write to the latch port leaves the latch unchanged. A 1- or 2-byte read of it responds in the same cycle with rsp_unused=1 and all-ones data.
- R3: With latch bit 31 set, an access to data port 0xCFC+k of length L (1, 2 or 4, with k+L<=4) targets bus latch[23:16], device/function latch[15:8] (device in the upper 5 bits) and register {4'b0, latch[7:2], k}. Byte enables are L ones shifted left by k, write data is shifted left by 8*k, and read data is the dword shifted right by 8*k and zero-extended to L bytes.
- R4: With latch bit 31 clear, a data-port read responds in the same cycle with all-ones and rsp_unused=0, and a data-port write raises no strobe.
- R5: A memory-window access at address A takes bus A[27:20], device/function A[19:12] and register A[11:0], with lengths 1, 2 or 4 and the same lane rules as R3.
- R6: A request for the local bus whose device is present asserts dev_sel in the request cycle. A read then responds in the next cycle with dev_rdata aligned as in R3, and pio_ready and mm_ready are low in that cycle.
- R7: A request for any other bus asserts brg_sel with brg_idx set to the lowest-index enabled bridge entry whose secondary <= bus <= subordinate. A read responds in the next cycle from brg_rdata.
- R8: A read with no present local device and no matching bridge responds in the same cycle with 0xFFFFFFFF and rsp_unused=0. A write with no target raises no strobe and produces no response.
- R9: dev_sel and brg_sel are never high together, and whenever either is high the byte enables are non-zero.
- R10: A read of the data window with a length other than 1, 2 or 4, or with k+L>4, and any read of an unclaimed I/O port respond with rsp_unused=1. The matching writes are dropped.
- R11: When both paths present a request in the same cycle, the port path is taken and mm_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_bus | input | 8 | Bus number of the local segment |
| brg_en | input | NUM_BRIDGES | Enable per bridge entry |
| brg_sec | input | NUM_BRIDGES*8 | Secondary bus number per entry |
| brg_sub | input | NUM_BRIDGES*8 | Subordinate bus number per entry |
| pio_valid | input | 1 | Port access request |
| pio_write | input | 1 | Port access is a write |
| pio_addr | input | PIO_AW | I/O port address |
| pio_len | input | 3 | Access length in bytes |
| pio_wdata | input | 32 | Port write data, right-aligned |
| pio_ready | output | 1 | Port request accepted this cycle |
| mm_valid | input | 1 | Memory-window access request |
| mm_write | input | 1 | Memory-window access is a write |
| mm_addr | input | MM_AW | Offset within the memory window |
| mm_len | input | 3 | Access length in bytes |
| mm_wdata | input | 32 | Memory write data, right-aligned |
| mm_ready | output | 1 | Memory request accepted this cycle |
| tgt_write | output | 1 | Routed request is a write |
| tgt_bus | output | 8 | Routed target bus |
| tgt_devfn | output | 8 | Routed device/function |
| tgt_reg | output | 12 | Routed register byte offset |
| tgt_be | output | 4 | Byte enables within the dword |
| tgt_wdata | output | 32 | Lane-aligned write data |
| dev_sel | output | 1 | Local device select strobe |
| dev_present | input | 1 | A device exists at tgt_devfn |
| dev_rdata | input | 32 | Device read dword, valid the cycle after dev_sel |
| brg_sel | output | 1 | Bridge forward strobe |
| brg_idx | output | IDX_W | Selected bridge entry |
| brg_rdata | input | 32 | Bridge read dword, valid the cycle after brg_sel |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| rsp_unused | output | 1 | Port not claimed for this access |

## Verification
The bench sets up overlapping bridge ranges, so a bus covered by two entries shows whether the lowest index wins. A reversed priority would forward bus 3 to entry 1. It probes both ends of each range and a disabled entry that would cover bus 12, so an exclusive comparison or a missing enable gate shows up as a wrong index or a false forward. Narrow data-port accesses at offsets 1 and 2 check that byte enables, write shifts and read extraction use the same lane. A design that forgot the shift would return the low bytes of the dword. Narrow latch writes, a cleared enable bit and an absent device check that nothing is strobed. They also check that the response arrives in the same cycle rather than one cycle late.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

   localparam int CFG_BUS_W = 8;
   localparam int CFG_REG_W = 12;

   typedef struct packed {
      logic                 valid;
      logic                 write;
      logic [CFG_BUS_W-1:0] bus;
      logic [7:0]           devfn;
      logic [CFG_REG_W-1:0] regofs;
      logic [2:0]           len;
      logic [31:0]          wdata;
   } cfg_req_t;

   // length must be 1, 2 or 4 and must stay inside the dword
   function automatic logic len_fits(input logic [1:0] off, input logic [2:0] len);
      logic [3:0] span;
      span = {2'b00, off} + {1'b0, len};
      return ((len == 3'd1) || (len == 3'd2) || (len == 3'd4)) && (span <= 4'd4);
   endfunction

   function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [2:0] len);
      logic [3:0] base;
      case (len)
         3'd1:    base = 4'b0001;
         3'd2:    base = 4'b0011;
         3'd4:    base = 4'b1111;
         default: base = 4'b0000;
      endcase
      return base << off;
   endfunction

   function automatic logic [31:0] lane_extract(input logic [31:0] d, input logic [1:0] off,
                                                input logic [2:0] len);
      logic [31:0] s;
      s = d >> {off, 3'b000};
      case (len)
         3'd1:    return {24'h0, s[7:0]};
         3'd2:    return {16'h0, s[15:0]};
         default: return s;
      endcase
   endfunction

endpackage

// File: rtl/cfg_pio_decode.sv
module cfg_pio_decode
   import cfg_router_pkg::*;
#(
   parameter int          PIO_AW     = 16,
   parameter logic [15:0] LATCH_PORT = 16'h0CF8,
   parameter logic [15:0] DATA_PORT  = 16'h0CFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  logic [PIO_AW-1:0] addr,
   input  logic [2:0]        len,
   input  logic [31:0]       wdata,
   output cfg_req_t          req,
   output logic              imm_valid,
   output logic [31:0]       imm_rdata,
   output logic              imm_unused
);

   logic [31:0] latch_q;
   logic        hit_latch;
   logic        hit_data;
   logic [1:0]  off;

   assign hit_latch = (addr == LATCH_PORT[PIO_AW-1:0]);
   assign hit_data  = (addr[PIO_AW-1:2] == DATA_PORT[PIO_AW-1:2]);
   assign off       = addr[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         latch_q <= '0;
      else if (acc && wr && hit_latch && (len == 3'd4))
         latch_q <= wdata;
   end

   always_comb begin
      req        = '0;
      imm_valid  = 1'b0;
      imm_rdata  = '1;
      imm_unused = 1'b0;
      if (acc) begin
         if (hit_latch) begin
            if (!wr) begin
               imm_valid = 1'b1;
               if (len == 3'd4) imm_rdata  = latch_q;
               else             imm_unused = 1'b1;
            end
         end else if (hit_data) begin
            if (!len_fits(off, len)) begin
               imm_valid  = !wr;
               imm_unused = !wr;
            end else if (!latch_q[31]) begin
               imm_valid = !wr;
            end else begin
               req.valid  = 1'b1;
               req.write  = wr;
               req.bus    = latch_q[23:16];
               req.devfn  = latch_q[15:8];
               req.regofs = {4'b0000, latch_q[7:2], off};
               req.len    = len;
               req.wdata  = wdata;
            end
         end else if (!wr) begin
            imm_valid  = 1'b1;
            imm_unused = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfg_bridge_match.sv
module cfg_bridge_match #(
   parameter int NUM_BRIDGES = 8,
   parameter int BUS_W       = 8,
   localparam int IDX_W      = (NUM_BRIDGES > 1) ? $clog2(NUM_BRIDGES) : 1
) (
   input  logic [BUS_W-1:0]             bus,
   input  logic [NUM_BRIDGES-1:0]       en,
   input  logic [NUM_BRIDGES*BUS_W-1:0] sec,
   input  logic [NUM_BRIDGES*BUS_W-1:0] sub,
   output logic                         hit,
   output logic [IDX_W-1:0]             idx
);

   logic [NUM_BRIDGES-1:0] in_range;

   for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_entry
      assign in_range[g] = en[g]
                         && (bus >= sec[g*BUS_W +: BUS_W])
                         && (bus <= sub[g*BUS_W +: BUS_W]);
   end

   // scan from the top so the lowest matching index is the one kept
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM_BRIDGES - 1; i >= 0; i--) begin
         if (in_range[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/cfg_resp_path.sv
module cfg_resp_path
   import cfg_router_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch,
   input  logic        launch_brg,
   input  logic [1:0]  launch_off,
   input  logic [2:0]  launch_len,
   input  logic [31:0] dev_rdata,
   input  logic [31:0] brg_rdata,
   input  logic        imm_valid,
   input  logic [31:0] imm_rdata,
   input  logic        imm_unused,
   output logic        busy,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata,
   output logic        rsp_unused
);

   logic       pend_q;
   logic       src_brg_q;
   logic [1:0] off_q;
   logic [2:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         src_brg_q <= 1'b0;
         off_q     <= '0;
         len_q     <= '0;
      end else begin
         pend_q <= launch;
         if (launch) begin
            src_brg_q <= launch_brg;
            off_q     <= launch_off;
            len_q     <= launch_len;
         end
      end
   end

   assign busy       = pend_q;
   assign rsp_valid  = pend_q || imm_valid;
   assign rsp_unused = !pend_q && imm_unused;
   assign rsp_rdata  = pend_q ? lane_extract(src_brg_q ? brg_rdata : dev_rdata, off_q, len_q)
                              : imm_rdata;

endmodule

// File: rtl/cfg_req_router.sv
module cfg_req_router
   import cfg_router_pkg::*;
#(
   parameter int          NUM_BRIDGES = 8,
   parameter int          PIO_AW      = 16,
   parameter int          MM_AW       = 28,
   parameter logic [15:0] LATCH_PORT  = 16'h0CF8,
   parameter logic [15:0] DATA_PORT   = 16'h0CFC,
   localparam int         IDX_W       = (NUM_BRIDGES > 1) ? $clog2(NUM_BRIDGES) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [CFG_BUS_W-1:0]             local_bus,
   input  logic [NUM_BRIDGES-1:0]           brg_en,
   input  logic [NUM_BRIDGES*CFG_BUS_W-1:0] brg_sec,
   input  logic [NUM_BRIDGES*CFG_BUS_W-1:0] brg_sub,
   input  logic                             pio_valid,
   input  logic                             pio_write,
   input  logic [PIO_AW-1:0]                pio_addr,
   input  logic [2:0]                       pio_len,
   input  logic [31:0]                      pio_wdata,
   output logic                             pio_ready,
   input  logic                             mm_valid,
   input  logic                             mm_write,
   input  logic [MM_AW-1:0]                 mm_addr,
   input  logic [2:0]                       mm_len,
   input  logic [31:0]                      mm_wdata,
   output logic                             mm_ready,
   output logic                             tgt_write,
   output logic [CFG_BUS_W-1:0]             tgt_bus,
   output logic [7:0]                       tgt_devfn,
   output logic [CFG_REG_W-1:0]             tgt_reg,
   output logic [3:0]                       tgt_be,
   output logic [31:0]                      tgt_wdata,
   output logic                             dev_sel,
   input  logic                             dev_present,
   input  logic [31:0]                      dev_rdata,
   output logic                             brg_sel,
   output logic [IDX_W-1:0]                 brg_idx,
   input  logic [31:0]                      brg_rdata,
   output logic                             rsp_valid,
   output logic [31:0]                      rsp_rdata,
   output logic                             rsp_unused
);

   if (NUM_BRIDGES < 1) begin : g_bad_nb
      $error("NUM_BRIDGES must be at least 1");
   end
   if (MM_AW < 28) begin : g_bad_mm
      $error("MM_AW must cover bus, device/function and register fields");
   end
   if (PIO_AW < 3 || PIO_AW > 16) begin : g_bad_pio
      $error("PIO_AW must lie in 3..16");
   end
   if (DATA_PORT[1:0] != 2'b00) begin : g_bad_dp
      $error("DATA_PORT must be dword aligned");
   end

   logic        busy;
   logic        pio_acc;
   logic        mm_acc;
   cfg_req_t    pio_req;
   cfg_req_t    mm_req;
   cfg_req_t    req;
   logic        pio_imm_v;
   logic [31:0] pio_imm_d;
   logic        pio_imm_u;
   logic        mm_bad_rd;
   logic        is_local;
   logic        brg_hit;
   logic [IDX_W-1:0] brg_pick;
   logic        miss_rd;
   logic        launch;
   logic        imm_valid;
   logic [31:0] imm_rdata;
   logic        imm_unused;

   assign pio_ready = !busy;
   assign mm_ready  = !busy && !pio_valid;
   assign pio_acc   = pio_valid && pio_ready;
   assign mm_acc    = mm_valid && mm_ready;

   cfg_pio_decode #(
      .PIO_AW    (PIO_AW),
      .LATCH_PORT(LATCH_PORT),
      .DATA_PORT (DATA_PORT)
   ) u_pio (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (pio_acc),
      .wr        (pio_write),
      .addr      (pio_addr),
      .len       (pio_len),
      .wdata     (pio_wdata),
      .req       (pio_req),
      .imm_valid (pio_imm_v),
      .imm_rdata (pio_imm_d),
      .imm_unused(pio_imm_u)
   );

   // memory window: bus in [27:20], device/function in [19:12], register in [11:0]
   always_comb begin
      mm_req        = '0;
      mm_bad_rd     = 1'b0;
      if (mm_acc) begin
         if (len_fits(mm_addr[1:0], mm_len)) begin
            mm_req.valid  = 1'b1;
            mm_req.write  = mm_write;
            mm_req.bus    = mm_addr[27:20];
            mm_req.devfn  = mm_addr[19:12];
            mm_req.regofs = mm_addr[11:0];
            mm_req.len    = mm_len;
            mm_req.wdata  = mm_wdata;
         end else begin
            mm_bad_rd = !mm_write;
         end
      end
   end

   assign req = pio_req.valid ? pio_req : mm_req;

   assign tgt_write = req.write;
   assign tgt_bus   = req.bus;
   assign tgt_devfn = req.devfn;
   assign tgt_reg   = req.regofs;
   assign tgt_be    = lane_mask(req.regofs[1:0], req.len);
   assign tgt_wdata = req.wdata << {req.regofs[1:0], 3'b000};

   cfg_bridge_match #(
      .NUM_BRIDGES(NUM_BRIDGES),
      .BUS_W      (CFG_BUS_W)
   ) u_match (
      .bus(req.bus),
      .en (brg_en),
      .sec(brg_sec),
      .sub(brg_sub),
      .hit(brg_hit),
      .idx(brg_pick)
   );

   assign is_local = (req.bus == local_bus);
   assign dev_sel  = req.valid && is_local && dev_present;
   assign brg_sel  = req.valid && !is_local && brg_hit;
   assign brg_idx  = brg_pick;
   assign miss_rd  = req.valid && !req.write && !dev_sel && !brg_sel;
   assign launch   = (dev_sel || brg_sel) && !req.write;

   assign imm_valid  = pio_imm_v || mm_bad_rd || miss_rd;
   assign imm_rdata  = pio_imm_v ? pio_imm_d : 32'hFFFF_FFFF;
   assign imm_unused = (pio_imm_v && pio_imm_u) || mm_bad_rd;

   cfg_resp_path u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .launch_brg(brg_sel),
      .launch_off(req.regofs[1:0]),
      .launch_len(req.len),
      .dev_rdata (dev_rdata),
      .brg_rdata (brg_rdata),
      .imm_valid (imm_valid),
      .imm_rdata (imm_rdata),
      .imm_unused(imm_unused),
      .busy      (busy),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rsp_unused(rsp_unused)
   );

endmodule

// File: rtl/cfg_req_router_chk.sv
module cfg_req_router_chk #(
   parameter int          NUM_BRIDGES = 8,
   parameter int          PIO_AW      = 16,
   parameter logic [15:0] LATCH_PORT  = 16'h0CF8,
   parameter int          IDX_W       = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [7:0]               local_bus,
   input logic [NUM_BRIDGES-1:0]   brg_en,
   input logic [NUM_BRIDGES*8-1:0] brg_sec,
   input logic [NUM_BRIDGES*8-1:0] brg_sub,
   input logic                     pio_valid,
   input logic                     pio_write,
   input logic [PIO_AW-1:0]        pio_addr,
   input logic [2:0]               pio_len,
   input logic                     pio_ready,
   input logic                     mm_ready,
   input logic                     tgt_write,
   input logic [7:0]               tgt_bus,
   input logic [3:0]               tgt_be,
   input logic                     dev_sel,
   input logic                     brg_sel,
   input logic [IDX_W-1:0]         brg_idx,
   input logic                     rsp_valid,
   input logic [31:0]              rsp_rdata,
   input logic                     rsp_unused
);

   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_sel && brg_sel));

   p_be_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_sel || brg_sel) |-> (tgt_be != 4'b0000));

   p_hit_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_sel && !tgt_write) |=> (rsp_valid && !rsp_unused && !pio_ready && !mm_ready));

   p_stall_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pio_ready |-> (!dev_sel && !brg_sel));

   p_brg_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      brg_sel |-> (brg_en[brg_idx] && (tgt_bus != local_bus)
                   && (tgt_bus >= brg_sec[brg_idx*8 +: 8])
                   && (tgt_bus <= brg_sub[brg_idx*8 +: 8])));

   p_narrow_latch_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pio_valid && pio_ready && !pio_write && (pio_addr == LATCH_PORT[PIO_AW-1:0])
       && (pio_len != 3'd4)) |-> (rsp_valid && rsp_unused && (rsp_rdata == 32'hFFFF_FFFF)));

   p_mm_yield_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pio_valid |-> !mm_ready);

endmodule

bind cfg_req_router cfg_req_router_chk #(
   .NUM_BRIDGES(NUM_BRIDGES),
   .PIO_AW     (PIO_AW),
   .LATCH_PORT (LATCH_PORT),
   .IDX_W      (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .local_bus (local_bus),
   .brg_en    (brg_en),
   .brg_sec   (brg_sec),
   .brg_sub   (brg_sub),
   .pio_valid (pio_valid),
   .pio_write (pio_write),
   .pio_addr  (pio_addr),
   .pio_len   (pio_len),
   .pio_ready (pio_ready),
   .mm_ready  (mm_ready),
   .tgt_write (tgt_write),
   .tgt_bus   (tgt_bus),
   .tgt_be    (tgt_be),
   .dev_sel   (dev_sel),
   .brg_sel   (brg_sel),
   .brg_idx   (brg_idx),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .rsp_unused(rsp_unused)
);

// File: tb/cfg_req_router_tb.sv
`timescale 1ns/1ps
module cfg_req_router_tb;

   localparam int NB = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    local_bus = 8'd0;
   logic [NB-1:0] brg_en;
   logic [NB*8-1:0] brg_sec, brg_sub;
   logic          pio_valid = 0, pio_write = 0;
   logic [15:0]   pio_addr = '0;
   logic [2:0]    pio_len = '0;
   logic [31:0]   pio_wdata = '0;
   logic          pio_ready;
   logic          mm_valid = 0, mm_write = 0;
   logic [27:0]   mm_addr = '0;
   logic [2:0]    mm_len = '0;
   logic [31:0]   mm_wdata = '0;
   logic          mm_ready;
   logic          tgt_write;
   logic [7:0]    tgt_bus, tgt_devfn;
   logic [11:0]   tgt_reg;
   logic [3:0]    tgt_be;
   logic [31:0]   tgt_wdata;
   logic          dev_sel, dev_present, brg_sel;
   logic [31:0]   dev_rdata = '0, brg_rdata = '0;
   logic [2:0]    brg_idx;
   logic          rsp_valid, rsp_unused;
   logic [31:0]   rsp_rdata;

   always #2 clk = ~clk;

   cfg_req_router u_dut (.*);

   // device model: device 31 absent
   function automatic logic [31:0] devval(input logic [7:0] df, input logic [11:0] r);
      return {df, r[11:2], 2'b01, 12'hC3A};
   endfunction
   function automatic logic [31:0] brgval(input logic [7:0] b, input logic [7:0] df, input logic [2:0] i);
      return {b, df, 13'h00B0, i};
   endfunction
   function automatic logic [31:0] lanes(input logic [31:0] d, input int off, input int len);
      logic [31:0] s;
      s = d >> (8 * off);
      if (len == 1) return s & 32'hFF;
      if (len == 2) return s & 32'hFFFF;
      return s;
   endfunction

   assign dev_present = (tgt_devfn[7:3] != 5'd31);
   always_ff @(posedge clk) begin
      if (dev_sel && !tgt_write) dev_rdata <= devval(tgt_devfn, tgt_reg);
      if (brg_sel && !tgt_write) brg_rdata <= brgval(tgt_bus, tgt_devfn, brg_idx);
   end

   int checks = 0, fails = 0;
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard
   typedef struct { logic [31:0] d; logic u; string tag; } exp_t;
   exp_t sb[$];
   task automatic expect_rsp(input logic [31:0] d, input logic u, input string tag);
      exp_t e; e.d = d; e.u = u; e.tag = tag; sb.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) chk(1'b0, "unexpected response", rsp_rdata, 32'h0);
         else begin
            exp_t e;
            e = sb.pop_front();
            chk((rsp_rdata === e.d) && (rsp_unused === e.u), e.tag,
                {rsp_rdata[30:0], rsp_unused}, {e.d[30:0], e.u});
         end
      end
   end

   // snapshots
   logic s_dev, s_brg, s_rsp, s_mmr, s2_rdy, s2_rsp;
   logic [2:0] s_idx;
   logic [7:0] s_bus, s_df;
   logic [11:0] s_reg;
   logic [3:0] s_be;
   logic [31:0] s_wd;

   task automatic finish_cycle();
      @(negedge clk);
      s_dev = dev_sel; s_brg = brg_sel; s_rsp = rsp_valid; s_mmr = mm_ready;
      s_idx = brg_idx; s_bus = tgt_bus; s_df = tgt_devfn; s_reg = tgt_reg;
      s_be = tgt_be; s_wd = tgt_wdata;
      @(posedge clk); #1;
      pio_valid = 0; mm_valid = 0;
      @(negedge clk);
      s2_rdy = pio_ready; s2_rsp = rsp_valid;
   endtask

   task automatic pio(input logic w, input logic [15:0] a, input logic [2:0] l, input logic [31:0] d);
      @(posedge clk); #1;
      pio_valid = 1; pio_write = w; pio_addr = a; pio_len = l; pio_wdata = d;
      finish_cycle();
   endtask

   task automatic mm(input logic w, input logic [7:0] b, input logic [7:0] df, input logic [11:0] r,
                     input logic [2:0] l, input logic [31:0] d);
      @(posedge clk); #1;
      mm_valid = 1; mm_write = w; mm_addr = {b, df, r}; mm_len = l; mm_wdata = d;
      finish_cycle();
   endtask

   initial begin
      #800000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      brg_en = 8'b0000_1111 & ~8'b0000_0100;
      brg_en[2] = 1'b0;
      brg_sec = '0; brg_sub = '0;
      brg_sec[0*8 +: 8] = 8'd1;  brg_sub[0*8 +: 8] = 8'd4;
      brg_sec[1*8 +: 8] = 8'd3;  brg_sub[1*8 +: 8] = 8'd8;
      brg_sec[2*8 +: 8] = 8'd10; brg_sub[2*8 +: 8] = 8'd20;
      brg_sec[3*8 +: 8] = 8'd9;  brg_sub[3*8 +: 8] = 8'd9;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(pio_ready === 1'b1 && rsp_valid === 1'b0, "R6 reset ready/idle", {pio_ready, rsp_valid}, 2'b10);

      // R1 latch reset value and write/readback
      expect_rsp(32'h0, 1'b0, "R1 latch reset read");
      pio(0, 16'h0CF8, 4, 0);
      chk(s_rsp === 1'b1, "R1 latch read same cycle", s_rsp, 1);
      pio(1, 16'h0CF8, 4, 32'h8000_1A08);
      expect_rsp(32'h8000_1A08, 1'b0, "R1 latch readback");
      pio(0, 16'h0CF8, 4, 0);

      // R2 narrow latch access
      pio(1, 16'h0CF8, 2, 32'h0000_1234);
      expect_rsp(32'h8000_1A08, 1'b0, "R2 narrow write ignored");
      pio(0, 16'h0CF8, 4, 0);
      expect_rsp(32'hFFFF_FFFF, 1'b1, "R2 narrow latch read unused");
      pio(0, 16'h0CF8, 1, 0);

      // R3/R6 full read through data port: devfn 0x1A reg 0x08
      expect_rsp(devval(8'h1A, 12'h008), 1'b0, "R3 dword read data");
      pio(0, 16'h0CFC, 4, 0);
      chk(s_dev && !s_rsp && s_df == 8'h1A && s_reg == 12'h008 && s_be == 4'hF,
          "R3 strobe fields", {s_dev, s_rsp, s_df, s_reg, s_be}, {1'b1, 1'b0, 8'h1A, 12'h008, 4'hF});
      chk(s2_rsp === 1'b1 && s2_rdy === 1'b0, "R6 response next cycle, stall", {s2_rsp, s2_rdy}, 2'b10);

      // R3 word read at offset 2
      expect_rsp(lanes(devval(8'h1A, 12'h00A), 2, 2), 1'b0, "R3 word lane read");
      pio(0, 16'h0CFE, 2, 0);
      chk(s_be == 4'b1100 && s_reg == 12'h00A, "R3 word be/reg", {s_be, s_reg}, {4'b1100, 12'h00A});

      // R3 byte write at offset 1
      pio(1, 16'h0CFD, 1, 32'h0000_00AB);
      chk(s_dev && s_be == 4'b0010 && s_wd == 32'h0000_AB00 && !s_rsp && !s2_rsp,
          "R3 byte write lanes", s_wd, 32'h0000_AB00);

      // R8 absent local device
      pio(1, 16'h0CF8, 4, 32'h8000_F810);
      expect_rsp(32'hFFFF_FFFF, 1'b0, "R8 absent device read");
      pio(0, 16'h0CFC, 4, 0);
      chk(s_rsp === 1'b1 && !s_dev && !s_brg, "R8 miss same cycle", s_rsp, 1);
      pio(1, 16'h0CFC, 4, 32'h1);
      chk(!s_dev && !s_brg && !s_rsp && !s2_rsp, "R8 write dropped", {s_dev, s_brg}, 0);

      // R4 enable clear
      pio(1, 16'h0CF8, 4, 32'h0000_1A08);
      expect_rsp(32'hFFFF_FFFF, 1'b0, "R4 disabled read all-ones");
      pio(0, 16'h0CFC, 4, 0);
      chk(!s_dev && s_rsp, "R4 no strobe on read", {s_dev, s_rsp}, 2'b01);
      pio(1, 16'h0CFC, 4, 32'h5);
      chk(!s_dev && !s_brg, "R4 write no strobe", {s_dev, s_brg}, 0);

      // R10 bad size in data window and unclaimed port
      pio(1, 16'h0CF8, 4, 32'h8000_1A08);
      expect_rsp(32'hFFFF_FFFF, 1'b1, "R10 crossing read unused");
      pio(0, 16'h0CFE, 4, 0);
      pio(1, 16'h0CFF, 2, 32'h7);
      chk(!s_dev && !s_brg, "R10 crossing write dropped", s_dev, 0);
      expect_rsp(32'hFFFF_FFFF, 1'b1, "R10 unclaimed port");
      pio(0, 16'h0080, 4, 0);

      // R5 memory window
      expect_rsp(devval(8'h21, 12'h104), 1'b0, "R5 mm dword read");
      mm(0, 8'd0, 8'h21, 12'h104, 4, 0);
      chk(s_dev && s_df == 8'h21 && s_reg == 12'h104, "R5 mm decode", {s_df, s_reg}, {8'h21, 12'h104});
      expect_rsp(lanes(devval(8'h21, 12'h107), 3, 1), 1'b0, "R5 mm byte read");
      mm(0, 8'd0, 8'h21, 12'h107, 1, 0);
      mm(1, 8'd0, 8'h30, 12'h0F2, 2, 32'h0000_5566);
      chk(s_dev && s_be == 4'b1100 && s_wd == 32'h5566_0000 && s_reg == 12'h0F2,
          "R5 mm word write", s_wd, 32'h5566_0000);

      // R7 bridge routing
      expect_rsp(brgval(8'd3, 8'h08, 3'd0), 1'b0, "R7 overlap lowest wins");
      mm(0, 8'd3, 8'h08, 12'h000, 4, 0);
      chk(s_brg && !s_dev && s_idx == 3'd0, "R7 overlap index", s_idx, 0);
      expect_rsp(brgval(8'd5, 8'h08, 3'd1), 1'b0, "R7 bus5 data");
      mm(0, 8'd5, 8'h08, 12'h000, 4, 0);
      chk(s_brg && s_idx == 3'd1, "R7 bus5 index", s_idx, 1);
      mm(1, 8'd1, 8'h00, 12'h010, 4, 32'h9);
      chk(s_brg && s_idx == 3'd0, "R7 lower bound", s_idx, 0);
      mm(1, 8'd8, 8'h00, 12'h010, 4, 32'h9);
      chk(s_brg && s_idx == 3'd1, "R7 upper bound", s_idx, 1);
      mm(1, 8'd9, 8'h00, 12'h010, 4, 32'h9);
      chk(s_brg && s_idx == 3'd3, "R7 single bus entry", s_idx, 3);
      expect_rsp(32'hFFFF_FFFF, 1'b0, "R7 disabled entry miss");
      mm(0, 8'd12, 8'h00, 12'h000, 4, 0);
      chk(!s_brg && s_rsp, "R7 disabled entry no forward", s_brg, 0);
      expect_rsp(32'hFFFF_FFFF, 1'b0, "R8 no bridge read");
      mm(0, 8'd40, 8'h00, 12'h000, 4, 0);
      mm(1, 8'd40, 8'h00, 12'h000, 4, 32'h1);
      chk(!s_brg && !s_dev && !s_rsp, "R8 no bridge write dropped", s_brg, 0);

      // R11 simultaneous requests: port path wins
      @(posedge clk); #1;
      pio_valid = 1; pio_write = 1; pio_addr = 16'h0CFC; pio_len = 4; pio_wdata = 32'h11;
      mm_valid = 1; mm_write = 1; mm_addr = {8'd0, 8'h40, 12'h020}; mm_len = 4; mm_wdata = 32'h22;
      finish_cycle();
      chk(!s_mmr && s_dev && s_df == 8'h1A && s_wd == 32'h11, "R11 port priority", s_df, 8'h1A);

      // R9 one strobe at a time observed in every case above
      chk(!(s_dev && s_brg), "R9 single strobe", {s_dev, s_brg}, 2'b10);

      repeat (3) @(posedge clk);
      chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule